// File: doc/BRIEF.md
# EEPROM Page-Load and Programming Controller

This block is a clock-synchronous model of the write side of a byte-wide nonvolatile memory. A host drives active-low chip-enable, write-enable and output-enable strobes together with an address and a data byte. Each accepted write strobe places one byte into a page buffer. The buffer holds one slot per byte of a page and a valid bit for each slot. Once the host stops loading for longer than a byte-load window, the controller closes the page and enters a timed programming interval. At the end of that interval it commits only the slots that were loaded to a backing byte array.

The glitch filter on the two write strobes and the power-on write lockout screen out spurious writes. All time limits are expressed in clock cycles. The host watches a busy flag and can read back the address and data of the last accepted byte. A plain read through the same strobes returns the stored array contents.

With the default parameters the array has 2K locations (32 pages of 64 bytes), which keeps the elaborated register count small. Setting the address width to 13 gives the full 8K map.

Top module: `nvm_page_prog`

## Requirements
- R1: After reset, `busy`, `last_addr`, `last_data` and `rdata` are all zero, and every array location reads as zero.
- R2: For POR_CYC cycles after reset is released, completed write strobes are ignored: no load is taken and `busy` stays low.
- R3: A write strobe begins when the later of the filtered chip-enable and write-enable goes low while the other is already low and `oe_n` is high. The address is captured at that moment. The data byte is captured when the first of the two strobes returns high, and the accepted load then appears on `last_addr`/`last_data`. This holds whether write-enable or chip-enable falls last.
- R4: No load is taken while `oe_n` is low at strobe start, or while `ce_n` is held high.
- R5: A low pulse on `ce_n` or `we_n` shorter than FILT_CYC cycles does not change the filtered strobe and starts no write. A filtered strobe changes only after its raw input has held the new level.
- R6: `busy` rises exactly BLC_CYC cycles after the last accepted load if no further load arrives, stays high for exactly PROG_CYC cycles, and is entered only from the loading state.
- R7: Address bits 5..0 pick the slot within a page and the upper bits pick the page. A single page operation may load all 64 slots, and all of them are programmed together.
- R8: A load whose page bits differ from those of the first load of the current operation is discarded. It leaves `last_addr` unchanged and is not programmed.
- R9: Slots may be loaded in any order. Reloading a slot before programming replaces its byte, and the last value written is the one programmed.
- R10: Only slots that were loaded are updated in the array. The other locations of the page keep their contents.
- R11: Write strobes that complete while `busy` is high are ignored.
- R12: The array is updated at the end of the programming interval, so a read during `busy` returns the old contents. A read (`ce_n`=0, `oe_n`=0, `we_n`=1) returns the addressed byte on `rdata` one cycle later. At all other times `rdata` is zero.
- R13: The slot valid mask is cleared when programming ends. A later operation on another page therefore does not write slots loaded in an earlier operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page in upper bits, slot in bits 5..0 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data, zero when not reading |
| busy | output | 1 | High during the programming interval |
| last_addr | output | ADDR_W | Address of the last accepted load |
| last_data | output | 8 | Data of the last accepted load |

## Verification
The assertions check several properties on every cycle:
- each filtered strobe changes only after its raw pin has shown the new level;
- `last_addr`/`last_data` are frozen during the power-on lockout and while programming;
- the page bits of `last_addr` never move while a page is being loaded;
- `busy` is entered only from loading;
- the valid mask is empty whenever `busy` falls.

Only the bench scenarios can show the following:
- the exact cycle counts of the byte-load window and the programming interval;
- that glitches, inhibited strobes and loads to a foreign page leave the array unchanged;
- that overwritten slots keep their last value;
- that unloaded slots and other pages survive commits, including after a mask clear.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } prog_state_e;
endpackage

// File: rtl/nvm_strobe_filter.sv
// Per-line minimum-width filter: the filtered level follows the raw line
// only after the raw line has differed from it for MIN_CYC straight cycles.
module nvm_strobe_filter #(
    parameter int LINES   = 2,
    parameter int MIN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] filt
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic             lvl_d, lvl_q;

        always_comb begin
            lvl_d = lvl_q;
            cnt_d = '0;
            if (raw[g] != lvl_q) begin
                if (cnt_q == CNT_W'(MIN_CYC - 1)) begin
                    lvl_d = raw[g];
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                lvl_q <= lvl_d;
                cnt_q <= cnt_d;
            end
        end

        assign filt[g] = lvl_q;
    end
endmodule

// File: rtl/nvm_page_buf.sv
// Page latch: one byte plus one valid bit per slot.
module nvm_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int BYTE_W     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]       wr_slot,
    input  logic [BYTE_W-1:0]                   wr_data,
    input  logic                                clr,
    output logic [PAGE_BYTES-1:0][BYTE_W-1:0]   slot_data,
    output logic [PAGE_BYTES-1:0]               slot_vld
);
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]             vld_d, vld_q;

    always_comb begin
        data_d = data_q;
        vld_d  = vld_q;
        if (clr) begin
            vld_d = '0;
        end
        if (wr_en) begin
            data_d[wr_slot] = wr_data;
            vld_d[wr_slot]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= '0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign slot_data = data_q;
    assign slot_vld  = vld_q;
endmodule

// File: rtl/nvm_cell_array.sv
// Backing byte array: parallel commit of all valid slots, registered read.
module nvm_cell_array #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    parameter int BYTE_W     = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]      commit_page,
    input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]         slot_data,
    input  logic [PAGE_BYTES-1:0]                     slot_vld,
    input  logic                                      rd_en,
    input  logic [ADDR_W-1:0]                         rd_addr,
    output logic [BYTE_W-1:0]                         rd_data
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int DEPTH  = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (commit && slot_vld[s]) begin
                    mem_q[{commit_page, SLOT_W'(s)}] <= slot_data[s];
                end
            end
            rd_q <= rd_en ? mem_q[rd_addr] : '0;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/nvm_page_prog.sv
module nvm_page_prog
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    parameter int FILT_CYC   = 3,
    parameter int BLC_CYC    = 40,
    parameter int PROG_CYC   = 60,
    parameter int POR_CYC    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [BYTE_W-1:0] last_data
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int TMR_W  = $clog2(BLC_CYC + 1);
    localparam int PRG_W  = $clog2(PROG_CYC + 1);
    localparam int POR_W  = $clog2(POR_CYC + 1);

    typedef struct packed {
        prog_state_e       st;
        logic [POR_W-1:0]  por;
        logic [TMR_W-1:0]  tmr;
        logic [PRG_W-1:0]  prg;
        logic [PAGE_W-1:0] page;
        logic              wr_prev;
        logic              in_stb;
        logic [ADDR_W-1:0] stb_addr;
        logic [ADDR_W-1:0] last_addr;
        logic [BYTE_W-1:0] last_data;
    } ctl_t;

    ctl_t q, d;

    logic ce_f, we_f, wr_cond;
    logic ld_evt, ld_ok, commit;
    logic por_active, st_load, mask_empty;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] slot_data;
    logic [PAGE_BYTES-1:0]             slot_vld;

    nvm_strobe_filter #(.LINES(2), .MIN_CYC(FILT_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({we_n, ce_n}),
        .filt ({we_f, ce_f})
    );

    assign wr_cond = !ce_f && !we_f;

    always_comb begin
        d      = q;
        ld_evt = 1'b0;
        commit = 1'b0;

        if (q.por != '0) d.por = q.por - 1'b1;

        // strobe framing: open on the later falling strobe, close on the first rise
        d.wr_prev = wr_cond;
        if (!q.in_stb) begin
            if (wr_cond && !q.wr_prev && oe_n) begin
                d.in_stb   = 1'b1;
                d.stb_addr = addr;
            end
        end else if (!wr_cond) begin
            d.in_stb = 1'b0;
            ld_evt   = 1'b1;
        end

        ld_ok = ld_evt && (q.por == '0) && (q.st != ST_PROG) &&
                ((q.st == ST_IDLE) || (q.stb_addr[ADDR_W-1:SLOT_W] == q.page));

        unique case (q.st)
            ST_IDLE: begin
                if (ld_ok) begin
                    d.st   = ST_LOAD;
                    d.page = q.stb_addr[ADDR_W-1:SLOT_W];
                    d.tmr  = TMR_W'(BLC_CYC);
                end
            end
            ST_LOAD: begin
                if (ld_ok) begin
                    d.tmr = TMR_W'(BLC_CYC);
                end else if (q.tmr == TMR_W'(1)) begin
                    d.st  = ST_PROG;
                    d.prg = PRG_W'(PROG_CYC);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_PROG: begin
                if (q.prg == PRG_W'(1)) begin
                    commit = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.prg = q.prg - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (ld_ok) begin
            d.last_addr = q.stb_addr;
            d.last_data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.por <= POR_W'(POR_CYC);
        end else begin
            q <= d;
        end
    end

    nvm_page_buf #(.PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_ok),
        .wr_slot  (q.stb_addr[SLOT_W-1:0]),
        .wr_data  (wdata),
        .clr      (commit),
        .slot_data(slot_data),
        .slot_vld (slot_vld)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_page(q.page),
        .slot_data  (slot_data),
        .slot_vld   (slot_vld),
        .rd_en      (!ce_n && !oe_n && we_n),
        .rd_addr    (addr),
        .rd_data    (rdata)
    );

    assign por_active = (q.por != '0);
    assign st_load    = (q.st == ST_LOAD);
    assign mask_empty = (slot_vld == '0);
    assign busy       = (q.st == ST_PROG);
    assign last_addr  = q.last_addr;
    assign last_data  = q.last_data;
endmodule

// File: rtl/nvm_page_prog_chk.sv
module nvm_page_prog_chk #(
    parameter int ADDR_W = 11,
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              ce_f,
    input logic              we_f,
    input logic              busy,
    input logic              por_active,
    input logic              st_load,
    input logic              mask_empty,
    input logic [ADDR_W-1:0] last_addr,
    input logic [7:0]        last_data
);
    // R5: a filtered strobe only moves to a level its raw pin already showed
    p_filt_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_f != $past(ce_f)) |-> ($past(ce_n) == ce_f));
    p_filt_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_f != $past(we_f)) |-> ($past(we_n) == we_f));

    // R2: lockout freezes the load record and keeps programming off
    p_por_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> ($stable(last_addr) && $stable(last_data)));
    p_por_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |-> !busy);

    // R11: nothing is taken while programming
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    // R8: page bits stay fixed during loading
    p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_load |=> (last_addr[ADDR_W-1:SLOT_W] == $past(last_addr[ADDR_W-1:SLOT_W])));

    // R6: programming is entered only from loading
    p_busy_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(st_load));

    // R13: valid mask empty once programming ends
    p_mask_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> mask_empty);
endmodule

bind nvm_page_prog nvm_page_prog_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .ce_f      (ce_f),
    .we_f      (we_f),
    .busy      (busy),
    .por_active(por_active),
    .st_load   (st_load),
    .mask_empty(mask_empty),
    .last_addr (last_addr),
    .last_data (last_data)
);

// File: tb/nvm_page_prog_tb.sv
module nvm_page_prog_tb;
    localparam int ADDR_W   = 11;
    localparam int SLOT_W   = 6;
    localparam int PAGE_W   = ADDR_W - SLOT_W;
    localparam int NPAGES   = 1 << PAGE_W;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int FILT_CYC = 3;
    localparam int BLC_CYC  = 40;
    localparam int PROG_CYC = 60;
    localparam int POR_CYC  = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              busy;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        last_data;

    always #5 clk = ~clk;

    nvm_page_prog #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(64), .FILT_CYC(FILT_CYC),
        .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
        .last_addr(last_addr), .last_data(last_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0]  exp_mem [DEPTH];
    logic [7:0]  pend_d  [64];
    logic [63:0] pend_v;
    logic [PAGE_W-1:0] pend_pg;
    bit          pend_open;

    function automatic logic [ADDR_W-1:0] mk(input int p, input int s);
        return {PAGE_W'(p), SLOT_W'(s)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_load(input logic [ADDR_W-1:0] a, input logic [7:0] v);
        if (!pend_open) begin
            pend_open = 1'b1;
            pend_pg   = a[ADDR_W-1:SLOT_W];
        end
        if (a[ADDR_W-1:SLOT_W] == pend_pg) begin
            pend_d[a[SLOT_W-1:0]] = v;
            pend_v[a[SLOT_W-1:0]] = 1'b1;
        end
    endtask

    task automatic model_commit();
        for (int s = 0; s < 64; s++)
            if (pend_v[s]) exp_mem[{pend_pg, SLOT_W'(s)}] = pend_d[s];
        pend_v    = '0;
        pend_open = 1'b0;
    endtask

    // mode 0: write-enable falls last, 1: chip-enable falls last,
    // 2: output-enable held low, 3: chip-enable held high
    task automatic load_byte(input logic [ADDR_W-1:0] a, input logic [7:0] v, input int mode);
        addr  = a;
        wdata = v;
        oe_n  = (mode == 2) ? 1'b0 : 1'b1;
        if (mode == 1) begin we_n = 1'b0; tick(2); ce_n = 1'b0; end
        else if (mode == 3) begin ce_n = 1'b1; tick(2); we_n = 1'b0; end
        else begin ce_n = 1'b0; tick(2); we_n = 1'b0; end
        tick(FILT_CYC + 3);
        if (mode == 1) ce_n = 1'b1; else we_n = 1'b1;
        tick(FILT_CYC + 3);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(2);
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick(2);
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_done();
        int g = 0;
        while (!busy && g < 2000) begin tick(1); g++; end
        while (busy && g < 4000) begin tick(1); g++; end
        tick(2);
        model_commit();
    endtask

    task automatic check_page(input int p, input string req);
        logic [7:0] v;
        for (int s = 0; s < 64; s++) begin
            read_byte(mk(p, s), v);
            chk(req, v, exp_mem[mk(p, s)]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt, dur, seed;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        pend_v = '0; pend_open = 1'b0; pend_pg = '0;
        seed = $urandom(32'd4021);

        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 last_addr", last_addr, 0);
        chk("R1 last_data", last_data, 0);
        chk("R1 rdata", rdata, 0);

        // R2 write inside power-on lockout
        load_byte(mk(1, 5), 8'h5A, 0);
        tick(BLC_CYC + 10);
        chk("R2 busy", busy, 0);
        chk("R2 last_data", last_data, 0);
        read_byte(mk(1, 5), v);
        chk("R2 array", v, 0);
        tick(POR_CYC);

        // R5 short write pulse
        addr = mk(2, 3); wdata = 8'hEE; oe_n = 1'b1; ce_n = 1'b0; tick(2);
        we_n = 1'b0; tick(FILT_CYC - 1); we_n = 1'b1; tick(2); ce_n = 1'b1;
        tick(BLC_CYC + 5);
        chk("R5 last_addr", last_addr, 0);
        chk("R5 busy", busy, 0);

        // R4 inhibited strobes
        load_byte(mk(2, 4), 8'hE1, 2);
        tick(BLC_CYC + 5);
        chk("R4 oe low last_addr", last_addr, 0);
        chk("R4 oe low busy", busy, 0);
        load_byte(mk(2, 6), 8'hE2, 3);
        tick(BLC_CYC + 5);
        chk("R4 ce high last_addr", last_addr, 0);
        chk("R4 ce high busy", busy, 0);

        // R3/R6/R10/R12 directed write-enable-controlled byte
        load_byte(mk(3, 5), 8'hC3, 0);
        model_load(mk(3, 5), 8'hC3);
        chk("R3 last_addr", last_addr, mk(3, 5));
        chk("R3 last_data", last_data, 8'hC3);
        cnt = FILT_CYC + 5;
        while (!busy && cnt < 1000) begin tick(1); cnt++; end
        chk("R6 window", cnt, FILT_CYC + 1 + BLC_CYC);
        dur = 0;
        while (busy && dur < 1000) begin tick(1); dur++; end
        chk("R6 prog length", dur, PROG_CYC);
        tick(2);
        model_commit();
        read_byte(mk(3, 5), v);
        chk("R12 readback", v, 8'hC3);
        read_byte(mk(3, 6), v);
        chk("R10 neighbour", v, 0);

        // R3 chip-enable-controlled, R12 read during busy shows old data
        load_byte(mk(3, 5), 8'h3C, 1);
        model_load(mk(3, 5), 8'h3C);
        chk("R3 ce last_data", last_data, 8'h3C);
        while (!busy) tick(1);
        read_byte(mk(3, 5), v);
        chk("R12 old during busy", v, 8'hC3);
        wait_done();
        read_byte(mk(3, 5), v);
        chk("R12 new after busy", v, 8'h3C);

        // R9 any order and overwrite
        load_byte(mk(7, 10), 8'h11, 0); model_load(mk(7, 10), 8'h11);
        load_byte(mk(7, 2), 8'h22, 0);  model_load(mk(7, 2), 8'h22);
        load_byte(mk(7, 10), 8'h33, 1); model_load(mk(7, 10), 8'h33);
        wait_done();
        read_byte(mk(7, 10), v); chk("R9 overwrite", v, 8'h33);
        read_byte(mk(7, 2), v);  chk("R9 order", v, 8'h22);

        // R8 foreign page load discarded
        load_byte(mk(4, 1), 8'hA1, 0); model_load(mk(4, 1), 8'hA1);
        load_byte(mk(5, 1), 8'hB1, 0); model_load(mk(5, 1), 8'hB1);
        chk("R8 last_addr", last_addr, mk(4, 1));
        wait_done();
        read_byte(mk(5, 1), v); chk("R8 foreign", v, 0);
        read_byte(mk(4, 1), v); chk("R8 own", v, 8'hA1);

        // R11 strobe during busy
        load_byte(mk(9, 0), 8'h90, 0); model_load(mk(9, 0), 8'h90);
        while (!busy) tick(1);
        load_byte(mk(9, 3), 8'h93, 0);
        chk("R11 last_addr", last_addr, mk(9, 0));
        wait_done();
        read_byte(mk(9, 3), v); chk("R11 array", v, 0);

        // R13 mask cleared between operations
        load_byte(mk(10, 7), 8'h77, 0); model_load(mk(10, 7), 8'h77);
        wait_done();
        load_byte(mk(11, 8), 8'h88, 0); model_load(mk(11, 8), 8'h88);
        wait_done();
        read_byte(mk(11, 7), v); chk("R13 stale slot", v, 0);
        read_byte(mk(11, 8), v); chk("R13 new slot", v, 8'h88);

        // R7 full page
        for (int s = 0; s < 64; s++) begin
            load_byte(mk(12, 63 - s), 8'(s * 3 + 1), 0);
            model_load(mk(12, 63 - s), 8'(s * 3 + 1));
        end
        wait_done();
        check_page(12, "R7 full page");

        // random page operations (R7 R8 R9 R10)
        for (int op = 0; op < 6; op++) begin
            int p, n;
            p = int'($urandom_range(NPAGES - 1, 13));
            n = int'($urandom_range(6, 1));
            for (int k = 0; k < n; k++) begin
                logic [ADDR_W-1:0] a;
                logic [7:0] dv;
                if ($urandom_range(3, 0) == 0 && k > 0) a = mk((p + 1) % NPAGES, int'($urandom_range(63, 0)));
                else a = mk(p, int'($urandom_range(63, 0)));
                dv = 8'($urandom);
                load_byte(a, dv, int'($urandom_range(1, 0)));
                model_load(a, dv);
            end
            wait_done();
            check_page(p, "R10 random page");
            check_page((p + 1) % NPAGES, "R8 random neighbour");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule